// File: doc/BRIEF.md
# Frame Buffer Fetch Engine

This block moves a frame buffer from memory into the on-chip pixel store of a display pipeline. At each frame start it takes a base address, the byte length of one line, the number of lines and the distance between line starts, then walks the frame and issues burst read requests on a simple request/response port. The port stands in for the system bus. Each returned beat is counted into the pixel store. The display side reports every beat it takes out of the store.

Before it issues a burst, the engine checks two things: that the store has room for it, and that the number of unanswered requests is below the programmed limit. Room is counted as the store's capacity less the beats already held and the beats requested but not yet returned. When every beat of the frame has been returned, it raises a one-cycle completion pulse. If the display side reports that it ran dry, the engine issues nothing more until the next frame start.

Top module: `fb_fetch_engine`

## Requirements
- R1: After reset, and until the first frame start, `req_valid` and `fetch_done` are both low.
- R2: The burst size in beats is `cfg_burst_len`, with 0 treated as 1 and any value above 16 treated as 16. A burst never crosses the end of a line, so the last burst of a line carries only the beats left in that line. Within a line, each request address follows the previous one by the previous request's beats times 8 bytes.
- R3: `cfg_max_out` sets the limit on outstanding requests. A request counts as outstanding from its acceptance until its response beat with `rsp_last` high. A new request is offered only while the outstanding count is below the limit.
- R4: The pixel store holds 2048 bytes, which is 256 beats of 8 bytes. Each `rsp_valid` beat adds one stored beat. Each `pix_pop` takes one away, and a pop is ignored when the store is empty. A burst is offered only when 256 minus the stored beats minus the in-flight beats is at least the burst size.
- R5: A frame has `cfg_line_count` lines of `cfg_line_len` bytes each, where the length is a multiple of 8. Line k starts at base + k*pitch. The total of requested beats equals lines times length/8.
- R6: After an `underrun` pulse, no request is offered until the next `frame_start`. This holds even when the pulse falls in the cycle a request is accepted; that request still counts.
- R7: `fetch_done` rises for exactly one cycle once every beat of the frame has been requested and returned. A frame cut short by an underrun gives no pulse.
- R8: `frame_start` reloads the fetch address from `cfg_base`, restarts the line walk and clears the underrun stop. The first request of the new frame is at `cfg_base`.
- R9: Once `req_valid` is high, it stays high with the same `req_addr` and `req_beats` until accepted. The only exceptions are an `underrun` or a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Pulse: begin fetching a new frame |
| underrun | input | 1 | Pulse: display side ran out of pixels |
| cfg_base | input | 32 | Frame buffer start address |
| cfg_line_len | input | 16 | Bytes per line (multiple of 8) |
| cfg_line_count | input | 12 | Lines per frame |
| cfg_line_pitch | input | 32 | Address step between line starts |
| cfg_burst_len | input | 5 | Programmed beats per burst |
| cfg_max_out | input | 4 | Outstanding request limit |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Byte address of the burst |
| req_beats | output | 5 | Beats in the burst |
| rsp_valid | input | 1 | One 8-byte beat returned |
| rsp_last | input | 1 | Final beat of a request |
| pix_pop | input | 1 | Display took one beat from the store |
| fetch_done | output | 1 | One-cycle frame fetch completion |

## Verification
Two events can land on the same cycle: the underrun stop and the acceptance of a burst. The bench holds `req_ready` low while a burst is offered, which also shows that the offer is held steady. It then raises `req_ready` and `underrun` on the same cycle. The outcome passes if exactly that one burst is counted and nothing more is offered, even after the store is drained, with no completion pulse. The next frame start must then bring fetching back at the base address.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;
    localparam int unsigned BEAT_BYTES = 8;
    localparam int unsigned MAX_BURST  = 16;
    localparam int unsigned BUF_BYTES  = 2048;
    localparam int unsigned OUT_CAP    = 16;
endpackage

// File: rtl/fb_fetch_credit.sv
module fb_fetch_credit #(
    parameter int unsigned BUF_BEATS = 256,
    parameter int unsigned OUT_CAP   = 16,
    parameter int unsigned BW        = 5,
    parameter int unsigned LVL_W     = $clog2(BUF_BEATS + 1),
    parameter int unsigned OW        = $clog2(OUT_CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [BW-1:0]    issue_beats,
    input  logic             rsp_valid,
    input  logic             rsp_last,
    input  logic             pop,
    output logic [LVL_W-1:0] space,
    output logic [OW-1:0]    outstanding
);
    typedef struct packed {
        logic [LVL_W-1:0] stored;
        logic [LVL_W-1:0] inflight;
        logic [OW-1:0]    outs;
    } credit_t;

    credit_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.stored   = st_q.stored + LVL_W'(rsp_valid) - LVL_W'(pop && (st_q.stored != '0));
        st_d.inflight = st_q.inflight + (issue ? LVL_W'(issue_beats) : '0) - LVL_W'(rsp_valid);
        st_d.outs     = st_q.outs + OW'(issue) - OW'(rsp_valid && rsp_last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign space       = LVL_W'(BUF_BEATS) - st_q.stored - st_q.inflight;
    assign outstanding = st_q.outs;

    // R4: stored plus in-flight beats never exceed the store
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.stored} + {1'b0, st_q.inflight}) <= (LVL_W + 1)'(BUF_BEATS));

    // R3: a returning beat always belongs to an accepted request
    p_rsp_owed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (st_q.inflight != '0) && (st_q.outs != '0));

    // R3: outstanding count stays within hard capacity
    p_outs_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.outs <= OW'(OUT_CAP));
endmodule

// File: rtl/fb_fetch_walker.sv
module fb_fetch_walker #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LB_W    = 13,
    parameter int unsigned CNT_W   = 12,
    parameter int unsigned BW      = 5,
    parameter int unsigned BEAT_SH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LB_W-1:0]   cfg_line_beats,
    input  logic [CNT_W-1:0]  cfg_line_count,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [BW-1:0]     burst,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BW-1:0]     cur_beats,
    output logic              has_work
);
    typedef struct packed {
        logic [ADDR_W-1:0] line_addr;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] pitch;
        logic [LB_W-1:0]   line_left;
        logic [LB_W-1:0]   line_beats;
        logic [CNT_W-1:0]  lines_left;
        logic              active;
    } walk_t;

    walk_t wk_d, wk_q;
    logic [LB_W-1:0] rem;

    always_comb begin
        cur_beats = (wk_q.line_left < LB_W'(burst)) ? BW'(wk_q.line_left) : burst;
        rem       = wk_q.line_left - LB_W'(cur_beats);
        wk_d      = wk_q;
        if (start) begin
            wk_d.line_addr  = cfg_base;
            wk_d.addr       = cfg_base;
            wk_d.pitch      = cfg_pitch;
            wk_d.line_beats = cfg_line_beats;
            wk_d.line_left  = cfg_line_beats;
            wk_d.lines_left = cfg_line_count;
            wk_d.active     = (cfg_line_count != '0) && (cfg_line_beats != '0);
        end else if (advance && wk_q.active) begin
            wk_d.addr      = wk_q.addr + (ADDR_W'(cur_beats) << BEAT_SH);
            wk_d.line_left = rem;
            if (rem == '0) begin
                if (wk_q.lines_left <= CNT_W'(1)) begin
                    wk_d.active = 1'b0;
                end else begin
                    wk_d.lines_left = wk_q.lines_left - CNT_W'(1);
                    wk_d.line_addr  = wk_q.line_addr + wk_q.pitch;
                    wk_d.addr       = wk_q.line_addr + wk_q.pitch;
                    wk_d.line_left  = wk_q.line_beats;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign cur_addr = wk_q.addr;
    assign has_work = wk_q.active;

    // R2: an offered burst is non-empty and never above the programmed size
    p_beats_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        has_work |-> (cur_beats != '0) && (cur_beats <= burst));

    // R8: frame start reloads the address from the base
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> cur_addr == $past(cfg_base));
endmodule

// File: rtl/fb_fetch_engine.sv
module fb_fetch_engine
    import fb_fetch_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned CNT_W      = 12,
    parameter int unsigned BURST_W    = 5,
    parameter int unsigned MAXO_W     = 4,
    parameter int unsigned BEAT_B     = BEAT_BYTES,
    parameter int unsigned BURST_MAX  = MAX_BURST,
    parameter int unsigned STORE_B    = BUF_BYTES,
    parameter int unsigned OUTS_CAP   = OUT_CAP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               underrun,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [LEN_W-1:0]   cfg_line_len,
    input  logic [CNT_W-1:0]   cfg_line_count,
    input  logic [ADDR_W-1:0]  cfg_line_pitch,
    input  logic [BURST_W-1:0] cfg_burst_len,
    input  logic [MAXO_W-1:0]  cfg_max_out,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [BURST_W-1:0] req_beats,
    input  logic               rsp_valid,
    input  logic               rsp_last,
    input  logic               pix_pop,
    output logic               fetch_done
);
    localparam int unsigned BUF_BEATS = STORE_B / BEAT_B;
    localparam int unsigned BEAT_SH   = $clog2(BEAT_B);
    localparam int unsigned BW        = $clog2(BURST_MAX + 1);
    localparam int unsigned LVL_W     = $clog2(BUF_BEATS + 1);
    localparam int unsigned OW        = $clog2(OUTS_CAP + 1);
    localparam int unsigned LB_W      = LEN_W - BEAT_SH;

    typedef struct packed {
        logic stop;
        logic pend;
        logic done;
    } ctl_t;

    ctl_t ct_d, ct_q;

    logic [BW-1:0]     burst_eff;
    logic [BW-1:0]     cur_beats;
    logic [ADDR_W-1:0] cur_addr;
    logic              has_work;
    logic [LVL_W-1:0]  space;
    logic [OW-1:0]     outs;
    logic              accept;

    always_comb begin
        if (cfg_burst_len == '0)                      burst_eff = BW'(1);
        else if (cfg_burst_len > BURST_W'(BURST_MAX)) burst_eff = BW'(BURST_MAX);
        else                                          burst_eff = BW'(cfg_burst_len);
    end

    fb_fetch_walker #(
        .ADDR_W (ADDR_W),
        .LB_W   (LB_W),
        .CNT_W  (CNT_W),
        .BW     (BW),
        .BEAT_SH(BEAT_SH)
    ) walker_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (frame_start),
        .cfg_base      (cfg_base),
        .cfg_line_beats(cfg_line_len[LEN_W-1:BEAT_SH]),
        .cfg_line_count(cfg_line_count),
        .cfg_pitch     (cfg_line_pitch),
        .burst         (burst_eff),
        .advance       (accept),
        .cur_addr      (cur_addr),
        .cur_beats     (cur_beats),
        .has_work      (has_work)
    );

    fb_fetch_credit #(
        .BUF_BEATS(BUF_BEATS),
        .OUT_CAP  (OUTS_CAP),
        .BW       (BW)
    ) credit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (accept),
        .issue_beats(cur_beats),
        .rsp_valid  (rsp_valid),
        .rsp_last   (rsp_last),
        .pop        (pix_pop),
        .space      (space),
        .outstanding(outs)
    );

    assign req_valid = has_work && !ct_q.stop
                    && (space >= LVL_W'(cur_beats))
                    && (outs < OW'(cfg_max_out));
    assign accept    = req_valid && req_ready;
    assign req_addr  = cur_addr;
    assign req_beats = BURST_W'(cur_beats);

    always_comb begin
        ct_d      = ct_q;
        ct_d.done = 1'b0;
        if (frame_start) begin
            ct_d.stop = 1'b0;
            ct_d.pend = 1'b1;
        end else if (underrun) begin
            ct_d.stop = 1'b1;
            ct_d.pend = 1'b0;
        end else if (ct_q.pend && !has_work && (outs == '0)) begin
            ct_d.pend = 1'b0;
            ct_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign fetch_done = ct_q.done;

    // R6: nothing is offered in the cycle after an underrun
    p_underrun_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(underrun) && !$past(frame_start)) |-> !req_valid);

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done);

    // R7: completion only with nothing outstanding and nothing offered
    p_done_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> (outs == '0) && !req_valid);

    // R9: an offered request holds until accepted
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !underrun && !frame_start)
        |=> req_valid && $stable(req_addr) && $stable(req_beats));

    // R5: line length is a whole number of beats
    p_len_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> cfg_line_len[BEAT_SH-1:0] == '0);
endmodule

// File: tb/fb_fetch_engine_tb.sv
`timescale 1ns/1ps
module fb_fetch_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        underrun = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_line_len = '0;
    logic [11:0] cfg_line_count = '0;
    logic [31:0] cfg_line_pitch = '0;
    logic [4:0]  cfg_burst_len = '0;
    logic [3:0]  cfg_max_out = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [4:0]  req_beats;
    logic        rsp_valid = 1'b0;
    logic        rsp_last = 1'b0;
    logic        pix_pop = 1'b0;
    logic        fetch_done;

    always #5 clk = ~clk;

    fb_fetch_engine dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .underrun(underrun),
        .cfg_base(cfg_base), .cfg_line_len(cfg_line_len), .cfg_line_count(cfg_line_count),
        .cfg_line_pitch(cfg_line_pitch), .cfg_burst_len(cfg_burst_len), .cfg_max_out(cfg_max_out),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .pix_pop(pix_pop), .fetch_done(fetch_done)
    );

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] len;
        logic [11:0] cnt;
        logic [31:0] pitch;
        logic [4:0]  burst;
        logic [3:0]  maxo;
        logic [31:0] reqs;
        logic [31:0] beats;
        logic [31:0] last_addr;
        logic [31:0] last_beats;
        logic [31:0] first_beats;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VECS [NVEC] = '{
        '{32'h1000, 16'd64,  12'd2, 32'h100, 5'd8,  4'd4, 32'd2, 32'd16, 32'h1100, 32'd8, 32'd8},
        '{32'h2000, 16'd40,  12'd3, 32'h40,  5'd2,  4'd1, 32'd9, 32'd15, 32'h20A0, 32'd1, 32'd2},
        '{32'h0000, 16'd160, 12'd1, 32'h0,   5'd20, 4'd2, 32'd2, 32'd20, 32'h0080, 32'd4, 32'd16},
        '{32'h3000, 16'd16,  12'd2, 32'h20,  5'd0,  4'd3, 32'd4, 32'd4,  32'h3028, 32'd1, 32'd1}
    };

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit timeout = 1'b0;

    int q_rem [32];
    int q_rd = 0, q_wr = 0, q_n = 0;
    int out_cnt = 0, viol = 0, cur_max = 0;
    int acc_beats = 0, dlv_beats = 0, pop_cnt = 0, pop_budget = 0;
    int nreq = 0, done_cnt = 0;
    bit done_drained = 1'b0;
    logic [31:0] first_addr = '0, last_addr = '0;
    int last_beats = 0, first_beats = 0;
    bit ready_en = 1'b0, ur_req = 1'b0, fs_req = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cyc > 150000) timeout = 1'b1;
        if (fetch_done) begin
            done_cnt++;
            done_drained = (dlv_beats == acc_beats) && (q_n == 0);
        end
        if (pop_budget > 0 && dlv_beats > pop_cnt) begin
            pix_pop = 1'b1; pop_cnt++; pop_budget--;
        end else pix_pop = 1'b0;
        frame_start = fs_req;
        underrun    = ur_req;
        fs_req = 1'b0;
        ur_req = 1'b0;
        req_ready = ready_en;
        if (req_valid && ready_en && out_cnt >= cur_max) viol++;
        if (q_n > 0) begin
            rsp_valid = 1'b1;
            rsp_last  = (q_rem[q_rd] == 1);
            q_rem[q_rd]--;
            dlv_beats++;
            if (q_rem[q_rd] == 0) begin
                q_rd = (q_rd + 1) % 32; q_n--; out_cnt--;
            end
        end else begin
            rsp_valid = 1'b0; rsp_last = 1'b0;
        end
        if (req_valid && ready_en) begin
            q_rem[q_wr] = int'(req_beats); q_wr = (q_wr + 1) % 32; q_n++;
            out_cnt++;
            acc_beats += int'(req_beats);
            nreq++;
            if (nreq == 1) begin first_addr = req_addr; first_beats = int'(req_beats); end
            last_addr = req_addr; last_beats = int'(req_beats);
        end
    endtask

    task automatic set_cfg(input vec_t v);
        cfg_base = v.base; cfg_line_len = v.len; cfg_line_count = v.cnt;
        cfg_line_pitch = v.pitch; cfg_burst_len = v.burst; cfg_max_out = v.maxo;
        cur_max = int'(v.maxo);
    endtask

    task automatic clear_counts();
        acc_beats = 0; dlv_beats = 0; pop_cnt = 0; nreq = 0; done_cnt = 0;
        viol = 0; done_drained = 1'b0;
    endtask

    task automatic run_vector(input int i);
        vec_t v;
        v = VECS[i];
        set_cfg(v);
        clear_counts();
        ready_en = 1'b1;
        pop_budget = 1000000;
        fs_req = 1'b1;
        step();
        for (int k = 0; k < 3000 && done_cnt == 0 && !timeout; k++) step();
        for (int k = 0; k < 5; k++) step();
        check(first_addr == v.base, $sformatf("R8 vec%0d first address", i), first_addr, v.base);
        check(first_beats == int'(v.first_beats), $sformatf("R2 vec%0d first burst", i), first_beats, v.first_beats);
        check(nreq == int'(v.reqs), $sformatf("R2 vec%0d request count", i), nreq, v.reqs);
        check(last_beats == int'(v.last_beats), $sformatf("R2 vec%0d trailing burst", i), last_beats, v.last_beats);
        check(last_addr == v.last_addr, $sformatf("R5 vec%0d last address", i), last_addr, v.last_addr);
        check(acc_beats == int'(v.beats), $sformatf("R5 vec%0d total beats", i), acc_beats, v.beats);
        check(viol == 0, $sformatf("R3 vec%0d outstanding limit", i), viol, 0);
        check(done_cnt == 1, $sformatf("R7 vec%0d done pulses", i), done_cnt, 1);
        check(done_drained, $sformatf("R7 vec%0d done after last return", i), done_drained, 1);
    endtask

    initial begin
        vec_t big;
        logic [31:0] held_addr;
        bit stable_ok;
        for (int k = 0; k < 32; k++) q_rem[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            check(req_valid == 1'b0, "R1 no request after reset", req_valid, 0);
            check(fetch_done == 1'b0, "R1 no done after reset", fetch_done, 0);
        end

        for (int i = 0; i < NVEC; i++) run_vector(i);

        // R4: store space gating without pops
        big = '{32'h8000, 16'd2400, 12'd1, 32'h0, 5'd16, 4'd15, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
        set_cfg(big);
        clear_counts();
        ready_en = 1'b1;
        pop_budget = 0;
        fs_req = 1'b1;
        step();
        for (int k = 0; k < 600; k++) step();
        check(acc_beats == 256, "R4 beats fetched into empty store", acc_beats, 256);
        check(req_valid == 1'b0, "R4 no request while store full", req_valid, 0);
        check(viol == 0, "R3 outstanding limit in fill", viol, 0);
        pop_budget = 16;
        for (int k = 0; k < 200; k++) step();
        check(acc_beats == 272, "R4 one burst after 16 pops", acc_beats, 272);

        // R9 and R6: hold the offer, then accept with underrun on the same cycle
        ready_en = 1'b0;
        pop_budget = 16;
        for (int k = 0; k < 100 && !req_valid; k++) step();
        check(req_valid == 1'b1, "R4 offer after space freed", req_valid, 1);
        check(req_addr == 32'h8880, "R2 address continues in line", req_addr, 32'h8880);
        held_addr = req_addr;
        stable_ok = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            if (!(req_valid && req_addr == held_addr && req_beats == 5'd16)) stable_ok = 1'b0;
        end
        check(stable_ok, "R9 offer held while not ready", stable_ok, 1);
        ready_en = 1'b1;
        ur_req = 1'b1;
        step();
        pop_budget = 1000000;
        for (int k = 0; k < 400; k++) step();
        check(acc_beats == 288, "R6 only the coincident burst counted", acc_beats, 288);
        check(req_valid == 1'b0, "R6 no offer after underrun", req_valid, 0);
        check(done_cnt == 0, "R7 no done for cut frame", done_cnt, 0);

        // R8: next frame resumes at the base
        run_vector(0);

        if (timeout) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule